// File: doc/BRIEF.md
# Rewindable Single-Clock FIFO with Half-Level Flag

This block is a single-clock first-in, first-out buffer with 9-bit words. Its depth is a parameter and is meant to be 256, 512 or 1024 words. A producer presents a word together with a one-cycle write enable. A consumer raises a one-cycle read enable, and the oldest word appears on the registered output one cycle later. Three active-low flags report the fill level: empty, full, and more than half full.

A rewind input, active low, moves the read side back to the first stored location. The buffer then delivers its contents again from the start. The write side does not move. Rewind is intended for short bursts, where fewer writes than the depth have happened since the last reset. A synchronous active-high reset empties the buffer.

Top module: `rewind_fifo`

## Requirements
- R1: While reset is high at a clock edge, the buffer empties. After that edge, empty_n is 0, full_n is 1, half_n is 1 and rd_data is 0.
- R2: Words come out in the order they were written. rd_data takes the new word at the edge where the read enable is accepted.
- R3: A write presented while full_n is 0 is dropped. It does not change the stored words or the read order.
- R4: A read presented while empty_n is 0 is dropped. rd_data keeps its value and the read position does not move.
- R5: full_n is 0 exactly when the stored count equals the depth.
- R6: When the count is exactly half the depth, a write with no read drives half_n to 0 from the next cycle.
- R7: half_n stays 0 until a read brings the count back to exactly half the depth. half_n is then 1.
- R8: A cycle with rewind_n at 0 and both enables at 0 moves the read position to location zero and leaves the write position alone. The flags then follow the new count, which equals the number of writes since reset.
- R9: When rewind_n is 0 and either enable is 1 in the same cycle, the rewind is ignored and the enables act as usual.
- R10: A write and a read in the same cycle, on a buffer that is neither empty nor full, both take effect and the count does not change.
- R11: empty_n is 0 exactly when the count is zero. It goes to 1 in the cycle after the first accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable, one cycle per word |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read enable, one cycle per word |
| rewind_n | input | 1 | Rewind request, active low |
| rd_data | output | 9 | Last word read, registered |
| empty_n | output | 1 | 0 when no word is stored |
| full_n | output | 1 | 0 when depth words are stored |
| half_n | output | 1 | 0 when more than half the depth is stored |

## Verification
A short vector table mixes several traffic patterns: plain writes, plain reads, a write and a read in the same cycle, a read on an empty buffer, a clean rewind, and a rewind that collides with a read. This separates a count that mishandles simultaneous operations from one that mishandles a rewind. Directed runs then fill the buffer across the half level in both directions, fill it to full, present a write while full, and drain it completely. The drain checks that every word arrives in order and that the dropped word never appears.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

    localparam int WORD_W = 9;

    // Operations accepted in one cycle
    typedef struct packed {
        logic push;
        logic pop;
        logic rewind;
    } fifo_op_t;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'b00,
        CNT_DEC  = 2'b01,
        CNT_INC  = 2'b10,
        CNT_SWAP = 2'b11
    } cnt_step_e;

    function automatic cnt_step_e step_of(input fifo_op_t op);
        return cnt_step_e'({op.push, op.pop});
    endfunction

endpackage

// File: rtl/rewind_fifo_ctrl.sv
module rewind_fifo_ctrl
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          rewind_n,
    output fifo_op_t      op,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    always_comb begin
        op.push   = wr_en && (count != FULL_C);
        op.pop    = rd_en && (count != '0);
        op.rewind = !rewind_n && !wr_en && !rd_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (op.rewind) begin
            // No wrap has happened, so the write position equals the word count
            rd_ptr <= '0;
            count  <= {1'b0, wr_ptr};
        end else begin
            if (op.push) wr_ptr <= wr_ptr + 1'b1;
            if (op.pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case (step_of(op))
                CNT_INC:  count <= count + 1'b1;
                CNT_DEC:  count <= count - 1'b1;
                default:  count <= count;
            endcase
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_C);

    a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (count == FULL_C && wr_en && !rd_en) |=> ($stable(wr_ptr) && count == FULL_C));

    a_r4_empty_read_dropped: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && rd_en && !wr_en) |=> ($stable(rd_ptr) && count == '0));

    a_r10_both_keep_count: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && count != '0 && count != FULL_C) |=> $stable(count));

    a_r8_rewind_moves_read_only: assert property (@(posedge clk) disable iff (rst)
        (!rewind_n && !wr_en && !rd_en) |=> (rd_ptr == '0 && $stable(wr_ptr)));

    a_r9_rewind_blocked: assert property (@(posedge clk) disable iff (rst)
        (!rewind_n && rd_en && !wr_en && count > CW'(1)) |=> rd_ptr != '0);

endmodule

// File: rtl/rewind_fifo_store.sv
module rewind_fifo_store
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [AW-1:0]     rd_ptr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)      rd_data <= '0;
        else if (pop) rd_data <= mem[rd_ptr];
    end

    a_r4_data_held: assert property (@(posedge clk) disable iff (rst)
        (!pop && !$past(rst)) |=> $stable(rd_data));

endmodule

// File: rtl/rewind_fifo_flags.sv
module rewind_fifo_flags #(
    parameter int DEPTH = 256,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    always_comb begin
        empty_n = (count != '0);
        full_n  = (count != FULL_C);
        half_n  = !(count > HALF_C);
    end

    a_r7_half_release: assert property (@(posedge clk) disable iff (rst)
        ($rose(half_n) && !$past(rst)) |-> count == HALF_C);

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> (full_n && half_n));

    a_r5_full_implies_half: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> !half_n);

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [8:0]        wr_data,
    input  logic              rd_en,
    input  logic              rewind_n,
    output logic [8:0]        rd_data,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

    fifo_op_t      op;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;

    rewind_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rewind_n(rewind_n),
        .op(op), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
    );

    rewind_fifo_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst(rst), .push(op.push), .pop(op.pop),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_data(wr_data), .rd_data(rd_data)
    );

    rewind_fifo_flags #(.DEPTH(DEPTH)) flags_i (
        .clk(clk), .rst(rst), .count(count),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!empty_n && full_n && half_n && rd_data == '0));

    a_r6_half_set: assert property (@(posedge clk) disable iff (rst)
        (count == HALF_C && op.push && !op.pop) |=> !half_n);

    a_r11_first_write: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && op.push) |=> empty_n);

endmodule

// File: tb/rewind_fifo_tb_top.sv
module rewind_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 256;
    localparam int NVEC = 13;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rewind_n = 1'b1;
    logic [8:0] rd_data;
    logic       empty_n, full_n, half_n;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rewind_fifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rewind_n(rewind_n), .rd_data(rd_data), .empty_n(empty_n),
        .full_n(full_n), .half_n(half_n)
    );

    // {wr, rd, rewind_n, din[8:0], exp_empty_n, exp_full_n, exp_half_n, chk, exp_dout[8:0]}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b1, 9'h011, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000},
        {1'b1, 1'b0, 1'b1, 9'h022, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000},
        {1'b1, 1'b0, 1'b1, 9'h1A3, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000},
        {1'b0, 1'b1, 1'b1, 9'h000, 1'b1, 1'b1, 1'b1, 1'b1, 9'h011},
        {1'b1, 1'b1, 1'b1, 9'h044, 1'b1, 1'b1, 1'b1, 1'b1, 9'h022},
        {1'b0, 1'b1, 1'b1, 9'h000, 1'b1, 1'b1, 1'b1, 1'b1, 9'h1A3},
        {1'b0, 1'b1, 1'b1, 9'h000, 1'b0, 1'b1, 1'b1, 1'b1, 9'h044},
        {1'b0, 1'b1, 1'b1, 9'h000, 1'b0, 1'b1, 1'b1, 1'b1, 9'h044},
        {1'b0, 1'b0, 1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000},
        {1'b0, 1'b1, 1'b1, 9'h000, 1'b1, 1'b1, 1'b1, 1'b1, 9'h011},
        {1'b0, 1'b1, 1'b0, 9'h000, 1'b1, 1'b1, 1'b1, 1'b1, 9'h022},
        {1'b0, 1'b1, 1'b1, 9'h000, 1'b1, 1'b1, 1'b1, 1'b1, 9'h1A3},
        {1'b0, 1'b1, 1'b1, 9'h000, 1'b0, 1'b1, 1'b1, 1'b1, 9'h044}
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 1, 2: return "R11 writes";
            4:       return "R10 write+read";
            7:       return "R4 read on empty";
            8:       return "R8 rewind";
            9:       return "R8 reread after rewind";
            10:      return "R9 rewind with read";
            default: return "R2 order";
        endcase
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle from a negedge; on return the edge has passed and inputs are idle
    task automatic step(input logic w, input logic r, input logic rw_n, input logic [8:0] d);
        wr_en = w; rd_en = r; rewind_n = rw_n; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rewind_n = 1'b1; wr_data = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 empty_n", {8'h0, empty_n}, 9'h0);
        check("R1 full_n", {8'h0, full_n}, 9'h1);
        check("R1 half_n", {8'h0, half_n}, 9'h1);
        check("R1 rd_data", rd_data, 9'h0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][24], VEC[i][23], VEC[i][22], VEC[i][21:13]);
            check({row_tag(i), " empty_n"}, {8'h0, empty_n}, {8'h0, VEC[i][12]});
            check({row_tag(i), " full_n"}, {8'h0, full_n}, {8'h0, VEC[i][11]});
            check({row_tag(i), " half_n"}, {8'h0, half_n}, {8'h0, VEC[i][10]});
            if (VEC[i][9]) check({row_tag(i), " rd_data"}, rd_data, VEC[i][8:0]);
        end

        // R1: reset with words stored
        step(1'b1, 1'b0, 1'b1, 9'h0AA);
        do_reset();
        check("R1 empty after reset", {8'h0, empty_n}, 9'h0);
        check("R1 data after reset", rd_data, 9'h0);

        // R6: fill to exactly half, then one more
        for (int i = 0; i < DEPTH / 2; i++) step(1'b1, 1'b0, 1'b1, 9'(i));
        check("R6 half_n at half", {8'h0, half_n}, 9'h1);
        step(1'b1, 1'b0, 1'b1, 9'(DEPTH / 2));
        check("R6 half_n past half", {8'h0, half_n}, 9'h0);
        // R7: one read back to exact half
        step(1'b0, 1'b1, 1'b1, 9'h0);
        check("R7 half_n released", {8'h0, half_n}, 9'h1);
        check("R2 first word", rd_data, 9'h0);

        // R5: fill to full
        for (int i = DEPTH / 2 + 1; i < DEPTH; i++) step(1'b1, 1'b0, 1'b1, 9'(i));
        check("R5 full_n one short", {8'h0, full_n}, 9'h1);
        step(1'b1, 1'b0, 1'b1, 9'(DEPTH));
        check("R5 full_n at depth", {8'h0, full_n}, 9'h0);
        check("R6 half_n when full", {8'h0, half_n}, 9'h0);
        // R3: write while full is dropped
        step(1'b1, 1'b0, 1'b1, 9'h1FF);
        check("R3 full_n stays", {8'h0, full_n}, 9'h0);
        step(1'b0, 1'b1, 1'b1, 9'h0);
        check("R5 full_n after read", {8'h0, full_n}, 9'h1);
        check("R2 order after full", rd_data, 9'h1);

        // R2/R3: drain all, dropped word must not appear
        for (int i = 2; i <= DEPTH; i++) begin
            step(1'b0, 1'b1, 1'b1, 9'h0);
            check("R3 drain order", rd_data, 9'(i));
        end
        check("R11 empty after drain", {8'h0, empty_n}, 9'h0);
        step(1'b0, 1'b1, 1'b1, 9'h0);
        check("R4 hold on empty", rd_data, 9'(DEPTH));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule